// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a virtual address into a physical address by walking a radix tree of translation tables held in memory. A requester presents a virtual address together with an access kind (read, write or execute), a flag saying whether it runs in user (problem) state, and the base and index width of the top-level table. The walker fetches one 64-bit entry per level over a small memory read port. At each level it either follows a directory entry down to the next table, or stops at a leaf entry or at an entry marked not valid.

At a leaf the walker checks the access against the entry's permission bits and its privileged flag. It reports a physical address and a fault code in a single-cycle completion pulse. Faults are split by side: a failing execute access raises an instruction-side fault and any other access raises a data-side fault. Two partition control inputs can turn translation off altogether. In that case the request fails at once and no memory read is issued. The walker serves one request at a time and limits a walk to a parameterised number of levels.

Top module: `radix_walker`

## Requirements
- R1: The walker takes a new request only while idle (`req_ready_o` high); `busy_o` is high from the cycle after acceptance until completion; completion is a single-cycle `done_o` pulse carrying `done_paddr_o` and `done_fault_o`.
- R2: Each table read is a 64-bit entry at address `table_base + index*8`. The index is the virtual-address field of `size` bits just below the remaining-bit count, which starts at `VA_W` and drops by each level's size. The request stays asserted with a stable address until `mem_req_ready_i` is high.
- R3: A level whose size is below 5 ends the walk with fault code 5 (bad level size) and physical address 0, with no read for that level.
- R4: An entry with bit 63 clear ends the walk with fault code 1 (instruction invalid) for an execute access, or code 2 (data invalid) otherwise. The reported address is the virtual address.
- R5: An entry with bits 63 and 62 set is a leaf. Its physical address is entry bits [PA_W-1:12], shifted into place, with the low `remaining` bits replaced by the same bits of the virtual address. With no permission fault the fault code is 0.
- R6: An execute access to a leaf raises fault code 3 (instruction permission) when execute bit 0 is clear, or when privileged bit 3 is set and the requester is in user state.
- R7: A read with read bit 2 clear, a write with write bit 1 clear, or any non-execute user access to a leaf with bit 3 set raises fault code 4 (data permission). The reported address is still the leaf address. Access kinds are encoded read=0, write=1, execute=2.
- R8: A valid directory entry (bit 62 clear) gives the next table base as entry bits [PA_W-1:0] with the low `DIR_ALIGN` bits cleared, and the next level size as entry bits [4:0].
- R9: With `part_host_radix_i` low and `part_vclass_i` at most 3, a request completes without any memory read. It reports fault code 1 for execute or 2 otherwise, with address 0.
- R10: If the entry fetched at level `MAX_LEVELS` is still a directory, the walk ends with fault code 6 (too deep) and address 0 after exactly `MAX_LEVELS` reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle, request taken |
| req_vaddr_i | input | VA_W | Virtual address |
| req_mode_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_user_i | input | 1 | Requester in user (problem) state |
| req_root_base_i | input | PA_W | Top-level table base |
| req_root_size_i | input | 5 | Top-level index width |
| part_host_radix_i | input | 1 | Partition radix translation enabled |
| part_vclass_i | input | VC_W | Partition virtualization class |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Completion pulse |
| done_paddr_o | output | PA_W | Resulting address |
| done_fault_o | output | 3 | Fault code (0 none) |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory accepts read |
| mem_req_addr_o | output | PA_W | Entry byte address |
| mem_rsp_valid_i | input | 1 | Read data present |
| mem_rsp_data_i | input | 64 | Entry read back |

## Verification
The bench places the leaf at the third level and sends every access kind at it, with every permission bit cleared in turn and with the privileged flag under both requester states. A design that swapped the instruction and data sides, or ignored the privileged bit, would report the wrong fault code. A directory entry carries junk in the bits that alignment must clear; a walker that failed to clear them would fetch from an empty address and report an invalid fault. Size and depth corner cases check both the fault code and the exact number of reads issued: a root size of 4, a size of 4 inside a directory, and a chain of four directories. The partition gate is tried at class values 3 and 4, so an off-by-one in the comparison shows up as a missing or extra walk. One run stalls the memory ready line on alternate cycles to catch an address that moves while the request is held.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2
   } acc_mode_e;

   typedef enum logic [2:0] {
      FLT_NONE         = 3'd0,
      FLT_INST_INVALID = 3'd1,
      FLT_DATA_INVALID = 3'd2,
      FLT_INST_PERM    = 3'd3,
      FLT_DATA_PERM    = 3'd4,
      FLT_BAD_SIZE     = 3'd5,
      FLT_TOO_DEEP     = 3'd6
   } walk_fault_e;

   localparam int ENTRY_W        = 64;
   localparam int ENTRY_BYTES_L2 = 3;
   localparam int ENT_VALID      = 63;
   localparam int ENT_LEAF       = 62;
   localparam int ENT_PRIV       = 3;
   localparam int ENT_RD         = 2;
   localparam int ENT_WR         = 1;
   localparam int ENT_EX         = 0;
   localparam int LVL_SIZE_W     = 5;
   localparam int MIN_LVL_SIZE   = 5;

endpackage

// File: rtl/radix_entry_addr.sv
module radix_entry_addr
   import radix_walk_pkg::*;
#(
   parameter int VA_W       = 48,
   parameter int PA_W       = 56,
   parameter int RW         = 6,
   parameter bit SPAN_CHECK = 1'b1
) (
   input  logic [PA_W-1:0]       base_i,
   input  logic [VA_W-1:0]       vaddr_i,
   input  logic [RW-1:0]         remaining_i,
   input  logic [LVL_SIZE_W-1:0] size_i,
   output logic [PA_W-1:0]       addr_o,
   output logic                  size_ok_o
);

   logic [RW-1:0]   shamt;
   logic [VA_W-1:0] idx;
   logic            fits;

   assign shamt  = remaining_i - RW'(size_i);
   assign idx    = (vaddr_i >> shamt) & ~({VA_W{1'b1}} << size_i);
   assign addr_o = base_i + (PA_W'(idx) << ENTRY_BYTES_L2);

   generate
      if (SPAN_CHECK) begin : g_span
         assign fits = RW'(size_i) <= remaining_i;
      end else begin : g_nospan
         assign fits = 1'b1;
      end
   endgenerate

   assign size_ok_o = (size_i >= LVL_SIZE_W'(MIN_LVL_SIZE)) && fits;

endmodule

// File: rtl/radix_leaf_eval.sv
module radix_leaf_eval
   import radix_walk_pkg::*;
#(
   parameter int VA_W       = 48,
   parameter int PA_W       = 56,
   parameter int RW         = 6,
   parameter int PAGE_SHIFT = 12
) (
   input  logic [ENTRY_W-1:0] entry_i,
   input  logic [VA_W-1:0]    vaddr_i,
   input  logic [RW-1:0]      remaining_i,
   input  acc_mode_e          mode_i,
   input  logic               user_i,
   output logic [PA_W-1:0]    paddr_o,
   output walk_fault_e        fault_o
);

   logic [PA_W-1:0] page_base;
   logic [PA_W-1:0] off_mask;
   logic            priv_block;

   assign page_base  = {entry_i[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
   assign off_mask   = ~({PA_W{1'b1}} << remaining_i);
   assign paddr_o    = (page_base & ~off_mask) | (PA_W'(vaddr_i) & off_mask);
   assign priv_block = entry_i[ENT_PRIV] && user_i;

   always_comb begin
      fault_o = FLT_NONE;
      if (mode_i == ACC_EXEC) begin
         if (!entry_i[ENT_EX] || priv_block) fault_o = FLT_INST_PERM;
      end else if (priv_block ||
                   (mode_i == ACC_READ  && !entry_i[ENT_RD]) ||
                   (mode_i == ACC_WRITE && !entry_i[ENT_WR])) begin
         fault_o = FLT_DATA_PERM;
      end
   end

endmodule

// File: rtl/radix_walker.sv
module radix_walker
   import radix_walk_pkg::*;
#(
   parameter int VA_W       = 48,
   parameter int PA_W       = 56,
   parameter int PAGE_SHIFT = 12,
   parameter int DIR_ALIGN  = 8,
   parameter int MAX_LEVELS = 4,
   parameter int VC_W       = 3,
   parameter bit SPAN_CHECK = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid_i,
   output logic            req_ready_o,
   input  logic [VA_W-1:0] req_vaddr_i,
   input  logic [1:0]      req_mode_i,
   input  logic            req_user_i,
   input  logic [PA_W-1:0] req_root_base_i,
   input  logic [4:0]      req_root_size_i,
   input  logic            part_host_radix_i,
   input  logic [VC_W-1:0] part_vclass_i,
   output logic            busy_o,
   output logic            done_o,
   output logic [PA_W-1:0] done_paddr_o,
   output logic [2:0]      done_fault_o,
   output logic            mem_req_valid_o,
   input  logic            mem_req_ready_i,
   output logic [PA_W-1:0] mem_req_addr_o,
   input  logic            mem_rsp_valid_i,
   input  logic [63:0]     mem_rsp_data_i
);

   localparam int RW    = $clog2(VA_W + 1);
   localparam int LVL_W = $clog2(MAX_LEVELS + 1);
   localparam logic [PA_W-1:0] ALIGN_MASK = ~((PA_W'(1) << DIR_ALIGN) - PA_W'(1));

   initial begin
      va_fits_pa_chk : assert (VA_W <= PA_W && VA_W >= 32)
         else $error("VA_W must lie in 32..PA_W");
      pa_width_chk : assert (PA_W <= 62 && PAGE_SHIFT < PA_W)
         else $error("PA_W must leave room for the flag bits");
      align_chk : assert (DIR_ALIGN >= ENTRY_BYTES_L2 && DIR_ALIGN < PA_W)
         else $error("DIR_ALIGN out of range");
      levels_chk : assert (MAX_LEVELS >= 1)
         else $error("MAX_LEVELS must be positive");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} walk_st_e;

   walk_st_e              st_q;
   logic [VA_W-1:0]       va_q;
   acc_mode_e             mode_q;
   logic                  user_q;
   logic [PA_W-1:0]       base_q;
   logic [LVL_SIZE_W-1:0] size_q;
   logic [RW-1:0]         rem_q;
   logic [LVL_W-1:0]      lvl_q;
   logic                  done_q;
   logic [PA_W-1:0]       pa_q;
   walk_fault_e           fault_q;

   logic [PA_W-1:0] ent_addr;
   logic            size_ok;
   logic [RW-1:0]   rem_after;
   logic [PA_W-1:0] leaf_pa;
   walk_fault_e     leaf_fault;
   logic [PA_W-1:0] next_base;
   logic            part_block;
   logic            req_exec;

   radix_entry_addr #(
      .VA_W(VA_W), .PA_W(PA_W), .RW(RW), .SPAN_CHECK(SPAN_CHECK)
   ) u_addr (
      .base_i(base_q), .vaddr_i(va_q), .remaining_i(rem_q), .size_i(size_q),
      .addr_o(ent_addr), .size_ok_o(size_ok)
   );

   assign rem_after = rem_q - RW'(size_q);

   radix_leaf_eval #(
      .VA_W(VA_W), .PA_W(PA_W), .RW(RW), .PAGE_SHIFT(PAGE_SHIFT)
   ) u_leaf (
      .entry_i(mem_rsp_data_i), .vaddr_i(va_q), .remaining_i(rem_after),
      .mode_i(mode_q), .user_i(user_q), .paddr_o(leaf_pa), .fault_o(leaf_fault)
   );

   assign next_base  = mem_rsp_data_i[PA_W-1:0] & ALIGN_MASK;
   assign part_block = !part_host_radix_i && (part_vclass_i <= VC_W'(3));
   assign req_exec   = (req_mode_i == 2'd2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         va_q    <= '0;
         mode_q  <= ACC_READ;
         user_q  <= 1'b0;
         base_q  <= '0;
         size_q  <= '0;
         rem_q   <= '0;
         lvl_q   <= '0;
         done_q  <= 1'b0;
         pa_q    <= '0;
         fault_q <= FLT_NONE;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (req_valid_i) begin
                  va_q   <= req_vaddr_i;
                  mode_q <= acc_mode_e'(req_mode_i);
                  user_q <= req_user_i;
                  base_q <= req_root_base_i & ALIGN_MASK;
                  size_q <= req_root_size_i;
                  rem_q  <= RW'(VA_W);
                  lvl_q  <= '0;
                  if (part_block) begin
                     done_q  <= 1'b1;
                     pa_q    <= '0;
                     fault_q <= req_exec ? FLT_INST_INVALID : FLT_DATA_INVALID;
                  end else begin
                     st_q <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: begin
               if (!size_ok) begin
                  st_q    <= ST_IDLE;
                  done_q  <= 1'b1;
                  pa_q    <= '0;
                  fault_q <= FLT_BAD_SIZE;
               end else if (mem_req_ready_i) begin
                  st_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (mem_rsp_valid_i) begin
                  if (!mem_rsp_data_i[ENT_VALID]) begin
                     st_q    <= ST_IDLE;
                     done_q  <= 1'b1;
                     pa_q    <= PA_W'(va_q);
                     fault_q <= (mode_q == ACC_EXEC) ? FLT_INST_INVALID : FLT_DATA_INVALID;
                  end else if (mem_rsp_data_i[ENT_LEAF]) begin
                     st_q    <= ST_IDLE;
                     done_q  <= 1'b1;
                     pa_q    <= leaf_pa;
                     fault_q <= leaf_fault;
                  end else if (lvl_q == LVL_W'(MAX_LEVELS - 1)) begin
                     st_q    <= ST_IDLE;
                     done_q  <= 1'b1;
                     pa_q    <= '0;
                     fault_q <= FLT_TOO_DEEP;
                  end else begin
                     base_q <= next_base;
                     size_q <= mem_rsp_data_i[LVL_SIZE_W-1:0];
                     rem_q  <= rem_after;
                     lvl_q  <= lvl_q + LVL_W'(1);
                     st_q   <= ST_ISSUE;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready_o     = (st_q == ST_IDLE);
   assign busy_o          = (st_q != ST_IDLE);
   assign done_o          = done_q;
   assign done_paddr_o    = pa_q;
   assign done_fault_o    = fault_q;
   assign mem_req_valid_o = (st_q == ST_ISSUE) && size_ok;
   assign mem_req_addr_o  = ent_addr;

   // R1
   done_pulse_chk : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R1
   idle_quiet_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_req_valid_o);

   // R2
   req_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

   // R2
   entry_align_chk : assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid_o |-> (mem_req_addr_o[ENTRY_BYTES_L2-1:0] == '0));

   // R6
   inst_side_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && (done_fault_o == FLT_INST_PERM)) |-> (mode_q == ACC_EXEC));

   // R7
   data_side_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && (done_fault_o == FLT_DATA_PERM)) |-> (mode_q != ACC_EXEC));

   // R10
   level_cap_chk : assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (lvl_q < LVL_W'(MAX_LEVELS)));

endmodule

// File: tb/radix_walker_bench.sv
module radix_walker_bench;

   localparam int VA_W = 48;
   localparam int PA_W = 56;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic [VA_W-1:0] req_vaddr = '0;
   logic [1:0]      req_mode = 2'd0;
   logic            req_user = 1'b0;
   logic [PA_W-1:0] req_root = '0;
   logic [4:0]      req_size = '0;
   logic            hr = 1'b1;
   logic [2:0]      vc = 3'd0;
   logic            busy, done;
   logic [PA_W-1:0] done_pa;
   logic [2:0]      done_flt;
   logic            mreq_valid;
   logic            mreq_ready = 1'b1;
   logic [PA_W-1:0] mreq_addr;
   logic            mrsp_valid = 1'b0;
   logic [63:0]     mrsp_data = '0;

   always #2 clk = ~clk;

   radix_walker u_radix_walker (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
      .req_mode_i(req_mode), .req_user_i(req_user), .req_root_base_i(req_root),
      .req_root_size_i(req_size), .part_host_radix_i(hr), .part_vclass_i(vc),
      .busy_o(busy), .done_o(done), .done_paddr_o(done_pa), .done_fault_o(done_flt),
      .mem_req_valid_o(mreq_valid), .mem_req_ready_i(mreq_ready), .mem_req_addr_o(mreq_addr),
      .mem_rsp_valid_i(mrsp_valid), .mem_rsp_data_i(mrsp_data)
   );

   typedef struct {
      logic [PA_W-1:0] pa;
      logic [2:0]      flt;
      int              reads;
      string           tag;
   } exp_t;

   exp_t        sb[$];
   logic [63:0] mem [longint];
   int          n_chk = 0;
   int          n_fail = 0;
   int          rd_count = 0;
   bit          stall = 1'b0;
   bit          pend = 1'b0;
   logic [PA_W-1:0] pend_addr = '0;

   localparam logic [VA_W-1:0] VA0   = 48'h1234_5678_9ABC;
   localparam logic [PA_W-1:0] PAGE0 = 56'hAB_CDEF_0123_4000;
   localparam logic [PA_W-1:0] PAGE1 = 56'h12_3456_7800_0000;

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [PA_W-1:0] ea(logic [PA_W-1:0] base, logic [VA_W-1:0] va, int rem, int sz);
      logic [VA_W-1:0] idx;
      idx = (va >> (rem - sz)) & ((48'd1 << sz) - 48'd1);
      return base + PA_W'(idx) * 56'd8;
   endfunction

   function automatic logic [63:0] mk_dir(logic [PA_W-1:0] base, int sz);
      return (64'd1 << 63) | 64'(base) | 64'(sz);
   endfunction

   function automatic logic [63:0] mk_leaf(logic [PA_W-1:0] page, bit pv, bit r, bit w, bit x);
      return (64'd1 << 63) | (64'd1 << 62) | 64'(page & ~56'hFFF) |
             64'({pv, r, w, x});
   endfunction

   function automatic logic [PA_W-1:0] leaf_pa(logic [PA_W-1:0] page, logic [VA_W-1:0] va, int rem);
      logic [PA_W-1:0] m;
      m = (56'd1 << rem) - 56'd1;
      return (page & ~m) | (PA_W'(va) & m);
   endfunction

   // memory model: responds the cycle after each accepted read
   initial begin
      forever begin
         @(negedge clk);
         mrsp_valid = 1'b0;
         if (pend) begin
            mrsp_valid = 1'b1;
            mrsp_data  = mem.exists(longint'(pend_addr)) ? mem[longint'(pend_addr)] : 64'd0;
            pend = 1'b0;
         end
         mreq_ready = stall ? ~mreq_ready : 1'b1;
         if (mreq_valid && mreq_ready) begin
            pend = 1'b1;
            pend_addr = mreq_addr;
            rd_count++;
         end
      end
   end

   // monitor: pops expected results on each completion
   initial begin
      forever begin
         @(negedge clk);
         if (done) begin
            if (sb.size() == 0) begin
               n_chk++;
               n_fail++;
               $display("FAIL R1 unexpected done actual=1 expected=0");
            end else begin
               exp_t e;
               e = sb.pop_front();
               check({e.tag, " addr"}, 64'(done_pa), 64'(e.pa));
               check({e.tag, " fault"}, 64'(done_flt), 64'(e.flt));
               check({e.tag, " reads"}, 64'(rd_count), 64'(e.reads));
            end
         end
      end
   end

   task automatic run(string tag, logic [VA_W-1:0] va, logic [1:0] mode, bit user,
                      logic [PA_W-1:0] root, int sz, bit h, int v,
                      logic [PA_W-1:0] epa, logic [2:0] eflt, int erd);
      exp_t e;
      e.pa = epa; e.flt = eflt; e.reads = erd; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      rd_count  = 0;
      req_vaddr = va; req_mode = mode; req_user = user;
      req_root  = root; req_size = 5'(sz); hr = h; vc = 3'(v);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (sb.size() != 0) @(negedge clk);
      @(negedge clk);
      hr = 1'b1; vc = 3'd0;
   endtask

   task automatic set_tables(logic [63:0] leaf);
      mem.delete();
      mem[longint'(ea(56'h10000, VA0, 48, 13))] = (64'd1 << 63) | 64'h200E9;
      mem[longint'(ea(56'h20000, VA0, 35, 9))]  = mk_dir(56'h30000, 9);
      mem[longint'(ea(56'h30000, VA0, 26, 9))]  = leaf;
   endtask

   initial begin
      logic [PA_W-1:0] pa0;
      pa0 = leaf_pa(PAGE0, VA0, 17);

      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 reset busy", 64'(busy), 64'd0);
      check("R1 reset done", 64'(done), 64'd0);
      check("R1 reset ready", 64'(req_ready), 64'd1);
      check("R2 reset mem req", 64'(mreq_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 R8 read through three levels (directory carries junk below alignment)
      set_tables(mk_leaf(PAGE0, 0, 1, 1, 1));
      fork
         run("R5 R8 read walk", VA0, 2'd0, 0, 56'h10000, 13, 1, 0, pa0, 3'd0, 3);
         begin
            @(negedge clk); @(negedge clk);
            check("R1 busy during walk", 64'(busy), 64'd1);
            check("R1 ready during walk", 64'(req_ready), 64'd0);
         end
      join
      // R2 stalled memory ready
      stall = 1'b1;
      run("R2 stalled exec walk", VA0, 2'd2, 0, 56'h10000, 13, 1, 0, pa0, 3'd0, 3);
      stall = 1'b0;
      // R7 write with write bit clear, read with read bit clear
      set_tables(mk_leaf(PAGE0, 0, 1, 0, 1));
      run("R7 write denied", VA0, 2'd1, 0, 56'h10000, 13, 1, 0, pa0, 3'd4, 3);
      run("R7 read allowed", VA0, 2'd0, 0, 56'h10000, 13, 1, 0, pa0, 3'd0, 3);
      set_tables(mk_leaf(PAGE0, 0, 0, 1, 1));
      run("R7 read denied", VA0, 2'd0, 0, 56'h10000, 13, 1, 0, pa0, 3'd4, 3);
      // R6 execute bit clear
      set_tables(mk_leaf(PAGE0, 0, 1, 1, 0));
      run("R6 exec denied", VA0, 2'd2, 0, 56'h10000, 13, 1, 0, pa0, 3'd3, 3);
      // R6 R7 privileged leaf
      set_tables(mk_leaf(PAGE0, 1, 1, 1, 1));
      run("R7 priv user read", VA0, 2'd0, 1, 56'h10000, 13, 1, 0, pa0, 3'd4, 3);
      run("R6 priv user exec", VA0, 2'd2, 1, 56'h10000, 13, 1, 0, pa0, 3'd3, 3);
      run("R7 priv super write", VA0, 2'd1, 0, 56'h10000, 13, 1, 0, pa0, 3'd0, 3);
      // R4 invalid second-level entry
      mem.delete(longint'(ea(56'h20000, VA0, 35, 9)));
      run("R4 data invalid", VA0, 2'd1, 0, 56'h10000, 13, 1, 0, PA_W'(VA0), 3'd2, 2);
      run("R4 inst invalid", VA0, 2'd2, 0, 56'h10000, 13, 1, 0, PA_W'(VA0), 3'd1, 2);
      // R9 partition gate
      set_tables(mk_leaf(PAGE0, 0, 1, 1, 1));
      run("R9 gate data", VA0, 2'd0, 0, 56'h10000, 13, 0, 3, 56'd0, 3'd2, 0);
      run("R9 gate inst", VA0, 2'd2, 0, 56'h10000, 13, 0, 0, 56'd0, 3'd1, 0);
      run("R9 class 4 walks", VA0, 2'd0, 0, 56'h10000, 13, 0, 4, pa0, 3'd0, 3);
      // R3 bad sizes
      run("R3 root size 4", VA0, 2'd0, 0, 56'h10000, 4, 1, 0, 56'd0, 3'd5, 0);
      mem[longint'(ea(56'hA0000, VA0, 48, 13))] = mk_dir(56'hB0000, 4);
      run("R3 inner size 4", VA0, 2'd0, 0, 56'hA0000, 13, 1, 0, 56'd0, 3'd5, 1);
      // R10 depth cap
      mem[longint'(ea(56'h40000, VA0, 48, 5))] = mk_dir(56'h50000, 5);
      mem[longint'(ea(56'h50000, VA0, 43, 5))] = mk_dir(56'h60000, 5);
      mem[longint'(ea(56'h60000, VA0, 38, 5))] = mk_dir(56'h70000, 5);
      mem[longint'(ea(56'h70000, VA0, 33, 5))] = mk_dir(56'h90000, 5);
      run("R10 too deep", VA0, 2'd0, 0, 56'h40000, 5, 1, 0, 56'd0, 3'd6, 4);
      // R5 leaf at the top level
      mem[longint'(ea(56'hC0000, VA0, 48, 13))] = mk_leaf(PAGE1, 0, 1, 1, 1);
      run("R5 top leaf", VA0, 2'd0, 0, 56'hC0000, 13, 1, 0, leaf_pa(PAGE1, VA0, 35), 3'd0, 1);

      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule